// File: doc/BRIEF.md
# Single-Channel DMA Block Mover

This block copies a block of bytes between one I/O device and memory so that the processor does not have to carry each byte itself. Software loads a start address and an item count, then writes a control word. That write starts the transfer. The control word selects the direction, a device port number, an interrupt arm bit and one of three ways to get onto the memory bus.

The three bus modes are:
- **Burst:** hold the bus for the whole block.
- **Cycle-steal:** win the bus once per item.
- **Transparent:** never request the bus and use only the cycles the processor marks as bus-idle.

Each item moves in a single cycle, once the device handshake, the memory handshake and bus ownership are all present. The address steps up and the count steps down in that same cycle.

When the block ends, a status bit records completion and an armed interrupt fires. Reading the status register acknowledges both.

Top module: `dma_channel`

## Requirements
- R1: Register writes select by `cfg_addr`: 0 loads the start address, 1 loads the item count, and 2 writes the control word and starts the block. Control word fields are: bit 0 direction (1 = device to memory, 0 = memory to device), bits 2:1 mode (0 burst, 1 cycle-steal, 2 transparent, 3 acts as burst), bit 3 interrupt arm, bits 7:4 port number. The port number appears on `dev_port` from the cycle after the start.
- R2: A read with `cfg_addr` = 3 returns status on `cfg_rdata` in the same cycle: bit 0 done, bit 1 busy, other bits zero. Such a read clears done and `irq` at the next edge, unless a block completes at that same edge. After reset, status is zero and `irq` is low.
- R3: `mem_rd` and `mem_wr` are asserted only while `bus_req` and `bus_grant` are both high, or in transparent mode while `cpu_idle` is high. In burst and cycle-steal modes, `bus_req` rises in the cycle after the start.
- R4: In burst mode, `bus_req` stays high from the start until the last item has moved, and falls in the cycle after it.
- R5: In cycle-steal mode, `bus_req` is low in the cycle after each item that moves, and rises again while items remain.
- R6: In transparent mode, `bus_req` is never raised, and items move only in cycles where `cpu_idle` is high.
- R7: An item moves (`dev_ack` high) only in a cycle where `dev_ready` and `mem_ready` are both high together with bus ownership. Items use addresses start, start+1, and so on, in order.
  - Device to memory: `mem_wr` carries `dev_rdata` on `mem_wdata`.
  - Memory to device: `mem_rd` is asserted and `mem_rdata` is passed to `dev_wdata`.
- R8: The remaining count drops by one in each item's cycle with no extra cycle. A block ends after exactly the programmed number of items.
- R9: At block end, done is set. `irq` is raised only if the arm bit was set in the control word.
- R10: A start with a count of zero sets done (and `irq` if armed) at the start edge, moves nothing and never raises `bus_req`.
- R11: While busy, writes to any register are ignored: the running block is not restarted, and the stored address and count are kept.
- R12: If `bus_grant` falls in the middle of a block, the memory strobes stop at once. The block resumes when the grant returns, with no item lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Status read data (zero when not reading status) |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Memory bus request to the processor |
| bus_grant | input | 1 | Memory bus grant from the processor |
| cpu_idle | input | 1 | Processor is not using the bus this cycle |
| mem_addr | output | AW | Memory address (zero when not strobing) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| dev_ready | input | 1 | Device has data, or can take data |
| dev_rdata | input | DW | Data from the device |
| dev_wdata | output | DW | Data to the device |
| dev_ack | output | 1 | An item moved this cycle |
| dev_port | output | PW | Port number of the current block |

## Verification
Blocks are run in both directions, in each of the three bus modes. The device and memory handshakes are either always ready or stalled on offset periodic patterns, so that waiting on the device is told apart from waiting on memory. In one burst block the grant is withdrawn partway through. This separates a controller that stops cleanly and resumes from one that drops, repeats or slips an address. A zero-count start, a block held ungranted while software rewrites registers, and a follow-up block started by the control write alone show whether the stored count and address survive ignored writes. Armed and unarmed blocks show that the interrupt follows the arm bit, while done is set in both.

// File: rtl/dmac_pkg.sv
// Shared definitions for the DMA channel: bus modes, register
// select codes and control-word bit positions.
package dmac_pkg;

    typedef enum logic [1:0] {
        XM_BURST = 2'd0,
        XM_STEAL = 2'd1,
        XM_IDLE  = 2'd2
    } xfer_mode_e;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_LEN  = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int CTL_DIR     = 0;
    localparam int CTL_MODE_LO = 1;
    localparam int CTL_ARM     = 3;
    localparam int CTL_PORT_LO = 4;

endpackage

// File: rtl/dmac_regs.sv
// Register front end: holds start address and count, produces the
// start pulse on a control write while idle, keeps the done and
// interrupt flags, and returns status on a read.
// Assumes AW and CW are no wider than CFG_W.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CW    = 8,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             busy,
    input  logic             finish,
    input  logic             finish_irq,
    output logic [AW-1:0]    base,
    output logic [CW-1:0]    len,
    output logic             start,
    output logic [CFG_W-1:0] ctrl,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             irq
);

    logic [AW-1:0] base_q;
    logic [CW-1:0] len_q;
    logic          done_q;
    logic          irq_q;
    logic          stat_rd;

    assign stat_rd = cfg_rd && (cfg_addr == REG_STAT);
    assign start   = cfg_wr && !busy && (cfg_addr == REG_CTRL);
    assign ctrl    = cfg_wdata;
    assign base    = base_q;
    assign len     = len_q;
    assign irq     = irq_q;

    // Status word: busy in bit 1, done in bit 0, returned only on a status read.
    assign cfg_rdata = stat_rd ? CFG_W'({busy, done_q}) : '0;

    // Capture address and count writes; ignored while a block runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (cfg_wr && !busy) begin
            if (cfg_addr == REG_BASE) base_q <= cfg_wdata[AW-1:0];
            if (cfg_addr == REG_LEN)  len_q  <= cfg_wdata[CW-1:0];
        end
    end

    // Completion flags: set at block end, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (finish)       done_q <= 1'b1;
            else if (stat_rd) done_q <= 1'b0;
            if (finish_irq)   irq_q  <= 1'b1;
            else if (stat_rd) irq_q  <= 1'b0;
        end
    end

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !finish) |=> (!done_q && !irq_q));

    assert_irq_has_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> done_q);

    assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> ($stable(base_q) && $stable(len_q)));

endmodule

// File: rtl/dmac_engine.sv
// Transfer engine: latches a block on start, decides bus ownership
// per mode, and moves one item per cycle in which ownership, device
// readiness and memory readiness coincide. Address and count are
// updated in the item's own cycle.
// Assumes bus_grant is only meaningful while bus_req is high.
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CW    = 8,
    parameter int PW    = 4,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base,
    input  logic [CW-1:0]    len,
    input  logic [CFG_W-1:0] ctrl,
    input  logic             bus_grant,
    input  logic             cpu_idle,
    input  logic             dev_ready,
    input  logic             mem_ready,
    output logic             busy,
    output logic             finish,
    output logic             finish_irq,
    output logic             bus_req,
    output logic             slot,
    output logic             item,
    output logic [AW-1:0]    addr,
    output logic             dir,
    output logic [PW-1:0]    port
);

    xfer_mode_e    mode_q;
    xfer_mode_e    new_mode;
    logic          busy_q, req_q, dir_q, arm_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] port_q;
    logic          own, last, empty_start;

    assign new_mode    = xfer_mode_e'(ctrl[CTL_MODE_LO +: 2]);
    assign empty_start = start && (len == '0);

    // Bus ownership this cycle: idle slots in transparent mode, else a granted request.
    always_comb begin
        if (mode_q == XM_IDLE) own = busy_q && cpu_idle;
        else                   own = busy_q && req_q && bus_grant;
    end

    assign slot       = own && dev_ready;
    assign item       = slot && mem_ready;
    assign last       = item && (cnt_q == CW'(1));
    assign finish     = empty_start || last;
    assign finish_irq = (empty_start && ctrl[CTL_ARM]) || (last && arm_q);

    assign busy    = busy_q;
    assign bus_req = req_q;
    assign addr    = addr_q;
    assign dir     = dir_q;
    assign port    = port_q;

    // Block state: load on start, step address and count on each item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= XM_BURST;
            dir_q  <= 1'b0;
            arm_q  <= 1'b0;
            port_q <= '0;
        end else if (start) begin
            busy_q <= (len != '0);
            addr_q <= base;
            cnt_q  <= len;
            mode_q <= new_mode;
            dir_q  <= ctrl[CTL_DIR];
            arm_q  <= ctrl[CTL_ARM];
            port_q <= ctrl[CTL_PORT_LO +: PW];
        end else if (item) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
            if (last) busy_q <= 1'b0;
        end
    end

    // Bus request: held for the block in burst, dropped after each item in steal, never in transparent.
    always_ff @(posedge clk) begin
        if (!rst_n)     req_q <= 1'b0;
        else if (start) req_q <= (len != '0) && (new_mode != XM_IDLE);
        else            req_q <= busy_q && !last && (mode_q != XM_IDLE)
                                 && !((mode_q == XM_STEAL) && item);
    end

    assert_burst_holds_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && req_q && (mode_q != XM_STEAL) && (mode_q != XM_IDLE) && !last) |=> req_q);

    assert_steal_drops_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == XM_STEAL) && item) |=> !req_q);

    assert_idle_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (mode_q == XM_IDLE)) |-> !req_q);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (item && !last) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !item && !start) |=> $stable(cnt_q));

    assert_empty_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        empty_start |=> (!busy_q && !req_q));

endmodule

// File: rtl/dma_channel.sv
// Top of the single-channel DMA: joins the register front end and the
// transfer engine, and steers data between device and memory ports.
// Memory-side outputs are zero whenever the channel is not strobing.
// Assumes memory completes an access in the cycle mem_ready is high.
module dma_channel
    import dmac_pkg::*;
#(
    parameter int AW    = 8,
    parameter int CW    = 8,
    parameter int DW    = 8,
    parameter int PW    = 4,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             irq,
    output logic             bus_req,
    input  logic             bus_grant,
    input  logic             cpu_idle,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    input  logic             dev_ready,
    input  logic [DW-1:0]    dev_rdata,
    output logic [DW-1:0]    dev_wdata,
    output logic             dev_ack,
    output logic [PW-1:0]    dev_port
);

    logic             busy, finish, finish_irq, start, slot, item, dir;
    logic [AW-1:0]    base, addr;
    logic [CW-1:0]    len;
    logic [CFG_W-1:0] ctrl;

    dmac_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .busy(busy),
        .finish(finish), .finish_irq(finish_irq), .base(base), .len(len),
        .start(start), .ctrl(ctrl), .cfg_rdata(cfg_rdata), .irq(irq)
    );

    dmac_engine #(.AW(AW), .CW(CW), .PW(PW), .CFG_W(CFG_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .len(len),
        .ctrl(ctrl), .bus_grant(bus_grant), .cpu_idle(cpu_idle),
        .dev_ready(dev_ready), .mem_ready(mem_ready), .busy(busy),
        .finish(finish), .finish_irq(finish_irq), .bus_req(bus_req),
        .slot(slot), .item(item), .addr(addr), .dir(dir), .port(dev_port)
    );

    // Data steering: strobes and data only during an owned, device-ready slot.
    always_comb begin
        mem_addr  = slot ? addr : '0;
        mem_rd    = slot && !dir;
        mem_wr    = slot && dir;
        mem_wdata = (slot && dir) ? dev_rdata : '0;
        dev_wdata = (slot && !dir) ? mem_rdata : '0;
        dev_ack   = item;
    end

    assert_strobe_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !cpu_idle) |-> (bus_req && bus_grant));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_ack_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (dev_ready && mem_ready && (mem_rd || mem_wr)));

endmodule

// File: tb/test_dma_channel.sv
// Scoreboard bench: the driver pushes expected (address, data) items,
// the monitor pops one per dev_ack and compares; bus-policy counters
// are checked at the end of each block.
module test_dma_channel;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       irq, bus_req, mem_rd, mem_wr, dev_ack;
    logic       bus_grant = 1'b0, cpu_idle = 1'b0, mem_ready = 1'b1, dev_ready = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;
    logic [3:0] dev_port;

    logic [7:0] mem [0:255];
    logic [7:0] dev_cnt = '0;
    int         tick = 0;
    bit         stall_on = 1'b0;
    bit         grant_block = 1'b0;
    logic [1:0] cur_mode = 2'd0;
    logic       cur_dir = 1'b0;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    int own_err = 0, idle_req_err = 0, steal_err = 0, burst_err = 0, extra_err = 0;
    int req_count = 0;
    logic prev_ack = 1'b0, prev_req = 1'b0;

    dma_channel i_dma_channel (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant), .cpu_idle(cpu_idle),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dev_ready(dev_ready), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_port(dev_port)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Processor model: grants one cycle after the request unless blocked.
    always @(posedge clk) bus_grant <= rst_n && bus_req && !grant_block;

    // Memory model: preset pattern on reset, writes on a ready write strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (mem_wr && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr];

    // Device model: data follows a counter that steps on every acknowledged item.
    always @(posedge clk) dev_cnt <= !rst_n ? 8'd0 : (dev_ack ? dev_cnt + 8'd1 : dev_cnt);
    assign dev_rdata = dev_cnt * 8'd3 + 8'd1;

    // Stall and idle patterns, changed on the falling edge.
    always @(negedge clk) begin
        tick      <= tick + 1;
        dev_ready <= !(stall_on && (tick % 5 == 3));
        mem_ready <= !(stall_on && (tick % 4 == 2));
        cpu_idle  <= (tick % 3 != 1);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: a quarter period after the falling edge, away from the active edge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if ((mem_rd || mem_wr) && !((bus_req && bus_grant) || (cur_mode == 2'd2 && cpu_idle)))
                own_err++;
            if (cur_mode == 2'd2 && bus_req) idle_req_err++;
            if (cur_mode == 2'd1 && prev_ack && bus_req) steal_err++;
            if (cur_mode == 2'd0 && prev_req && !bus_req && exp_q.size() != 0) burst_err++;
            if (bus_req) req_count++;
            if (dev_ack) begin
                if (exp_q.size() == 0) extra_err++;
                else begin
                    exp_t e;
                    logic [7:0] got;
                    e = exp_q.pop_front();
                    got = cur_dir ? mem_wdata : dev_wdata;
                    check(mem_addr == e.a, "R7 item address", mem_addr, e.a);
                    check(got == e.d, "R7 item data", got, e.d);
                end
            end
            prev_ack = dev_ack;
            prev_req = bus_req;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = 2'd3;
        #(CLK_PERIOD/4);
        v = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic push_items(input logic [7:0] base, input int len, input logic [7:0] ctrl);
        cur_mode = (ctrl[2:1] == 2'd3) ? 2'd0 : ctrl[2:1];
        cur_dir  = ctrl[0];
        for (int i = 0; i < len; i++) begin
            exp_t e;
            e.a = base + 8'(i);
            e.d = ctrl[0] ? 8'((dev_cnt + 8'(i)) * 8'd3 + 8'd1) : mem[base + 8'(i)];
            exp_q.push_back(e);
        end
    endtask

    task automatic launch(input logic [7:0] base, input int len, input logic [7:0] ctrl);
        push_items(base, len, ctrl);
        wr(2'd0, base);
        wr(2'd1, 8'(len));
        wr(2'd2, ctrl);
    endtask

    task automatic wait_drain(input string tag);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all items moved"}, exp_q.size(), 0);
        check(extra_err == 0, "R8 no extra items", extra_err, 0);
        check(own_err == 0, "R3 strobes only when owned", own_err, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int rc0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2, R3)
        check(bus_req == 1'b0, "R3 reset bus_req", bus_req, 0);
        check(irq == 1'b0, "R2 reset irq", irq, 0);
        check((mem_rd || mem_wr) == 1'b0, "R3 reset strobes", mem_rd || mem_wr, 0);
        rd_stat(v);
        check(v == 8'h00, "R2 reset status", v, 0);

        // Burst, memory to device, armed, port 5, no stalls (R1 R4 R7 R8 R9 R2)
        launch(8'h10, 6, 8'h58);
        check(dev_port == 4'd5, "R1 port number", dev_port, 5);
        wait_drain("R8 burst read");
        check(burst_err == 0, "R4 burst keeps request", burst_err, 0);
        check(bus_req == 1'b0, "R4 request dropped at end", bus_req, 0);
        check(irq == 1'b1, "R9 armed irq", irq, 1);
        rd_stat(v);
        check(v == 8'h01, "R2 done status", v, 1);
        check(irq == 1'b0, "R2 irq cleared by read", irq, 0);
        rd_stat(v);
        check(v == 8'h00, "R2 done cleared by read", v, 0);

        // Burst, device to memory, unarmed, stalls, grant withdrawn midway (R12 R9 R7)
        stall_on = 1'b1;
        launch(8'h40, 10, 8'h21);
        repeat (3) @(negedge clk);
        grant_block = 1'b1;
        repeat (5) @(negedge clk);
        check(bus_req == 1'b1, "R12 request held without grant", bus_req, 1);
        check(exp_q.size() > 0, "R12 block paused", exp_q.size(), 1);
        grant_block = 1'b0;
        wait_drain("R12 burst write");
        check(burst_err == 0, "R4 burst keeps request across grant loss", burst_err, 0);
        check(irq == 1'b0, "R9 unarmed no irq", irq, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 10; i++)
                if (mem[8'h40 + i] !== 8'((dev_cnt - 8'd10 + 8'(i)) * 8'd3 + 8'd1)) bad++;
            check(bad == 0, "R7 memory contents after write", bad, 0);
        end
        rd_stat(v);
        check(v == 8'h01, "R9 done without irq", v, 1);

        // Cycle-steal, device to memory, armed, stalls (R5)
        launch(8'h80, 5, 8'h1B);
        wait_drain("R5 steal write");
        check(steal_err == 0, "R5 request low after each item", steal_err, 0);
        check(irq == 1'b1, "R9 armed irq steal", irq, 1);
        rd_stat(v);
        check(v == 8'h01, "R5 done status", v, 1);

        // Transparent, memory to device, unarmed (R6)
        rc0 = req_count;
        launch(8'hC0, 5, 8'h34);
        wait_drain("R6 idle read");
        check(idle_req_err == 0, "R6 never requests", idle_req_err, 0);
        check(req_count == rc0, "R6 request count unchanged", req_count - rc0, 0);
        rd_stat(v);
        check(v == 8'h01, "R6 done status", v, 1);

        // Zero count start (R10)
        rc0 = req_count;
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h08);
        check(irq == 1'b1, "R10 armed irq on empty block", irq, 1);
        rd_stat(v);
        check(v == 8'h01, "R10 done immediately", v, 1);
        check(req_count == rc0, "R10 no bus request", req_count - rc0, 0);
        check(extra_err == 0, "R10 no item moved", extra_err, 0);

        // Writes while busy are ignored (R11)
        stall_on = 1'b0;
        grant_block = 1'b1;
        launch(8'h20, 8, 8'h70);
        repeat (3) @(negedge clk);
        rd_stat(v);
        check(v == 8'h02, "R2 busy status", v, 2);
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h90);
        wr(2'd2, 8'h70);
        grant_block = 1'b0;
        wait_drain("R11 first block");
        rd_stat(v);
        check(v == 8'h01, "R11 done after first block", v, 1);
        push_items(8'h20, 8, 8'h70);
        wr(2'd2, 8'h70);
        wait_drain("R11 stored address and count kept");
        check(dev_port == 4'd7, "R1 port number second block", dev_port, 7);

        finish_run();
    end

endmodule